// File: doc/BRIEF.md
# Link Signal Detect Qualifier

This block decides whether a received serial link is carrying valid line-coded data. On every word-clock cycle it receives one word holding two 10-bit characters from the deserializer, a single-bit amplitude-ok indication from an analog comparator outside the block, a loopback mode input and a comma-detect enable input. It produces one registered signal-detect flag.

Evaluation runs in fixed intervals of four word cycles, counted from reset release. During an interval the block collects failures: a low amplitude indication, a stuck all-zero or all-one character, and the end of a long watch window in which no negative-disparity K28.5 character appeared. At the last cycle of the interval the collected result is registered, and the flag holds that value for the whole of the next interval. The loopback and comma-enable inputs select which of the checks take part. The flag only reports link health and is not fed back into the receive path.

Top module: `sigdet_qual`

## Requirements
- R1: While reset is asserted, and after release until the end of the first four-cycle interval, `sig_ok` is low.
- R2: `sig_ok` changes only on the clock edge that ends an interval (the 4th, 8th, 12th... edge after reset release) and holds its value through every other edge.
- R3: If `amp_ok` is low in any cycle of an interval, `sig_ok` is low for the next interval, in every mode.
- R4: With `loopback` low, a character equal to 10'h000 in either slot (slot 0 = `rx_word[9:0]`, received first; slot 1 = `rx_word[19:10]`) in any cycle of an interval makes `sig_ok` low for the next interval.
- R5: With `loopback` low, a character equal to 10'h3FF in either slot in any cycle of an interval makes `sig_ok` low for the next interval.
- R6: With the K28.5- check enabled, the watch window spans WINDOW_CHARS characters (WINDOW_CHARS/2 word cycles, default 65560 characters). If no slot carries 10'h17C (bit 0 to bit 9: 0011111010) anywhere in a window, including its final cycle, `sig_ok` is low for the interval after the one in which the window ends. Each window starts right after the previous one, at reset release, or when the check becomes enabled.
- R7: With `loopback` low and `comma_en` high, the K28.5- check takes no part and its window is held at its start; the stuck-character checks stay active.
- R8: With `loopback` high, only the amplitude check takes part; stuck characters and a missing K28.5- have no effect on `sig_ok`.
- R9: `sig_ok` is high for the next interval when every check that takes part passed in every cycle of the current interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_word | input | 20 | Two received characters; slot 0 in bits 9:0 is the earlier one |
| amp_ok | input | 1 | Analog amplitude indication, high when the input swing is adequate |
| loopback | input | 1 | Loopback mode; restricts checking to amplitude |
| comma_en | input | 1 | Comma-detect enable; switches off the K28.5- check |
| sig_ok | output | 1 | Registered signal-detect flag |

## Verification
The assertions take for granted that `loopback` and `comma_en` are steady within an interval, so that one mode governs every cycle feeding a given result; the bench changes mode only on interval boundaries. They also assume the character inputs are defined in every cycle after reset; the bench drives fixed non-special filler characters in every slot and places the stuck and K28.5- characters in chosen cycles. The bench shrinks the watch window to 40 characters so that window ends fall on interval boundaries and both missed and last-cycle sightings can be reached quickly.

// File: rtl/sq_pkg.sv
package sq_pkg;

  localparam int CW = 10;

  typedef logic [CW-1:0] char_t;

  // negative-disparity K28.5, bit 0 received first: 0011111010
  localparam char_t K28_NEG = 10'h17C;

  function automatic logic is_all_zero(input char_t c);
    return (c == '0);
  endfunction

  function automatic logic is_all_one(input char_t c);
    return (&c);
  endfunction

  function automatic logic is_k28_neg(input char_t c);
    return (c == K28_NEG);
  endfunction

  // word cycles needed to cover a window of characters
  function automatic int win_cycles(input int chars, input int per_word);
    return (chars + per_word - 1) / per_word;
  endfunction

endpackage

// File: rtl/sq_char_scan.sv
module sq_char_scan
  import sq_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic [NCH*CW-1:0] word,
  output logic              zero_hit,
  output logic              ones_hit,
  output logic              k_hit
);

  logic [NCH-1:0] z_v, o_v, k_v;

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    assign z_v[i] = is_all_zero(word[i*CW +: CW]);
    assign o_v[i] = is_all_one(word[i*CW +: CW]);
    assign k_v[i] = is_k28_neg(word[i*CW +: CW]);
  end

  assign zero_hit = |z_v;
  assign ones_hit = |o_v;
  assign k_hit    = |k_v;

endmodule

// File: rtl/sq_k_window.sv
module sq_k_window #(
  parameter int WIN_CYC = 32780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic k_hit,
  output logic miss
);

  localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [WW-1:0] LAST = WW'(WIN_CYC - 1);

  logic [WW-1:0] cnt;
  logic          seen;
  logic          at_end;

  assign at_end = (cnt == LAST);
  assign miss   = enable && at_end && !(seen || k_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (!enable || at_end) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else begin
      cnt  <= cnt + 1'b1;
      seen <= seen | k_hit;
    end
  end

  // R6: window position never passes its last cycle
  p_win_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R6: a sighting inside a window prevents the miss at its end
  p_seen_no_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && k_hit && !at_end) |=> !miss);

endmodule

// File: rtl/sq_interval_eval.sv
module sq_interval_eval #(
  parameter int INTERVAL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic amp_bad,
  input  logic stuck_bad,
  input  logic k_bad,
  output logic interval_end,
  output logic sig_ok
);

  localparam int PW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [PW-1:0] PLAST = PW'(INTERVAL - 1);

  logic [PW-1:0] phase;
  logic          fail_acc;
  logic          fail_now;

  assign fail_now     = amp_bad || stuck_bad || k_bad;
  assign interval_end = (phase == PLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= '0;
      fail_acc <= 1'b0;
      sig_ok   <= 1'b0;
    end else if (interval_end) begin
      phase    <= '0;
      fail_acc <= 1'b0;
      sig_ok   <= !(fail_acc || fail_now);
    end else begin
      phase    <= phase + 1'b1;
      fail_acc <= fail_acc || fail_now;
    end
  end

  // R2: flag is held between interval ends
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !interval_end |=> $stable(sig_ok));

  // R1: flag can only rise right after an interval end
  p_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_ok) |-> $past(interval_end));

  // R3: low amplitude in the closing cycle forces the flag low
  p_amp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_end && amp_bad) |=> !sig_ok);

endmodule

// File: rtl/sigdet_qual.sv
module sigdet_qual
  import sq_pkg::*;
#(
  parameter int NCH          = 2,
  parameter int INTERVAL     = 4,
  parameter int WINDOW_CHARS = 65560
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*CW-1:0] rx_word,
  input  logic              amp_ok,
  input  logic              loopback,
  input  logic              comma_en,
  output logic              sig_ok
);

  localparam int WIN_CYC = win_cycles(WINDOW_CHARS, NCH);

  logic zero_hit, ones_hit, k_hit;
  logic stuck_on, k_on;
  logic stuck_bad, k_miss;
  logic interval_end;

  // mode table: loopback keeps only amplitude, comma enable drops K28.5-
  assign stuck_on  = !loopback;
  assign k_on      = !loopback && !comma_en;
  assign stuck_bad = stuck_on && (zero_hit || ones_hit);

  sq_char_scan #(.NCH(NCH)) u_scan (
    .word     (rx_word),
    .zero_hit (zero_hit),
    .ones_hit (ones_hit),
    .k_hit    (k_hit)
  );

  sq_k_window #(.WIN_CYC(WIN_CYC)) u_kwin (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (k_on),
    .k_hit  (k_hit),
    .miss   (k_miss)
  );

  sq_interval_eval #(.INTERVAL(INTERVAL)) u_eval (
    .clk          (clk),
    .rst_n        (rst_n),
    .amp_bad      (!amp_ok),
    .stuck_bad    (stuck_bad),
    .k_bad        (k_miss),
    .interval_end (interval_end),
    .sig_ok       (sig_ok)
  );

  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_end && !loopback && zero_hit) |=> !sig_ok);

  p_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_end && !loopback && ones_hit) |=> !sig_ok);

  p_kmiss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_end && k_miss) |=> !sig_ok);

  p_kdis_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (comma_en || loopback) |-> !k_miss);

  // R8: in loopback a good amplitude on the closing cycle with no
  // earlier failure source besides amplitude is not blocked by patterns
  p_loop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> !stuck_bad);

endmodule

// File: tb/sim_sigdet_qual.sv
`timescale 1ns/1ps
module sim_sigdet_qual;

  localparam int WCH   = 40;       // 20 word cycles = 5 intervals
  localparam int WIN_IV = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] rx_word = {10'h2AA, 10'h155};
  logic        amp_ok = 1'b1;
  logic        loopback = 1'b0;
  logic        comma_en = 1'b0;
  logic        sig_ok;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model state
  int kwin  = 0;
  bit kseen = 0;
  bit prev  = 0;

  always #2.5 clk = ~clk;

  sigdet_qual #(.NCH(2), .INTERVAL(4), .WINDOW_CHARS(WCH)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .amp_ok(amp_ok),
    .loopback(loopback), .comma_en(comma_en), .sig_ok(sig_ok)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: sig_ok=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // pat: 0 filler, 1 all-zero char in slot 1 of cycle 2,
  //      2 all-one char in slot 0 of cycle 1
  // amp=0: amp_ok low in cycle 1 only; wk: K28.5- in slot 1 of cycle 3
  task automatic run_iv(input int pat, input bit amp, input bit lb,
                        input bit ce, input bit wk, input string tag);
    bit exp, kon, kfail;
    for (int c = 0; c < 4; c++) begin
      if (c > 0) check(sig_ok, prev, "R2 hold");
      rx_word  = {10'h2AA, 10'h155};
      if (pat == 1 && c == 2) rx_word[19:10] = 10'h000;
      if (pat == 2 && c == 1) rx_word[9:0]   = 10'h3FF;
      if (wk && c == 3)       rx_word[19:10] = 10'h17C;
      amp_ok   = amp || (c != 1);
      loopback = lb;
      comma_en = ce;
      @(negedge clk);
    end
    kon   = !lb && !ce;
    kfail = 0;
    if (!kon) begin
      kwin = 0; kseen = 0;
    end else begin
      kseen = kseen | wk;
      kwin++;
      if (kwin == WIN_IV) begin
        kfail = !kseen;
        kwin = 0; kseen = 0;
      end
    end
    exp = amp && (lb || pat == 0) && !kfail;
    check(sig_ok, exp, tag);
    prev = exp;
  endtask

  task automatic t_reset();
    repeat (3) begin
      @(negedge clk);
      check(sig_ok, 1'b0, "R1 in reset");
    end
    rst_n = 1'b1;
    run_iv(0, 1, 0, 0, 0, "R1 first interval / R9");
  endtask

  task automatic t_normal();
    run_iv(0, 1, 0, 0, 0, "R9 clean");
    run_iv(0, 1, 0, 0, 0, "R9 clean");
    run_iv(0, 1, 0, 0, 0, "R9 clean");
    run_iv(0, 1, 0, 0, 1, "R6 sighting in final cycle");
  endtask

  task automatic t_stuck();
    run_iv(1, 1, 0, 0, 0, "R4 all-zero");
    run_iv(0, 1, 0, 0, 0, "R4 recover");
    run_iv(2, 1, 0, 0, 0, "R5 all-one");
    run_iv(0, 1, 0, 0, 0, "R5 recover");
  endtask

  task automatic t_kmiss();
    run_iv(0, 1, 0, 0, 0, "R6 window miss");
    run_iv(0, 1, 0, 0, 1, "R6 after miss");
    run_iv(0, 1, 0, 0, 0, "R6 mid window");
  endtask

  task automatic t_amp();
    run_iv(0, 0, 0, 0, 0, "R3 amplitude low");
    run_iv(0, 1, 0, 0, 1, "R3 recover");
  endtask

  task automatic t_comma();
    for (int i = 0; i < 6; i++) run_iv(0, 1, 0, 1, 0, "R7 no K needed");
    run_iv(1, 1, 0, 1, 0, "R7 stuck still active");
    run_iv(0, 1, 0, 1, 0, "R7 recover");
    for (int i = 0; i < 5; i++) run_iv(0, 1, 0, 0, 0, "R7 window restarted");
    run_iv(0, 1, 0, 0, 1, "R7 after re-enable");
  endtask

  task automatic t_loop();
    run_iv(1, 1, 1, 0, 0, "R8 all-zero ignored");
    run_iv(2, 1, 1, 1, 0, "R8 all-one ignored");
    for (int i = 0; i < 6; i++) run_iv(0, 1, 1, 0, 0, "R8 no K needed");
    run_iv(0, 0, 1, 0, 0, "R8 amplitude still checked");
    run_iv(0, 1, 0, 0, 1, "R8 leave loopback");
  endtask

  initial begin
    t_reset();
    t_normal();
    t_stuck();
    t_kmiss();
    t_amp();
    t_comma();
    t_loop();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule